// File: doc/BRIEF.md
# UART Autobaud Start-Bit Measurer

This block sets a UART's bit rate from the traffic it receives. Software arms it by writing the enable bit of a 32-bit control word. The block then waits for the next falling edge on the synchronized receive line. It counts how many system clocks the line stays low, which is the width of one start bit. From that width it computes a baud-generator divisor, assuming 16x oversampling. The divisor appears on a register output together with a one-cycle load strobe, and the enable then drops by itself.

A measurement that is too short to be a real start bit, or too long for the counter, raises a sticky error flag. In that case the divisor is not changed and the enable also drops by itself. The error flag stays set until a clear pulse arrives. The receiver data path and the baud generator are outside this block.

Top module: `abd_measure`

## Requirements
- R1: After reset the enable reads 0, the error flag reads 0, the divisor holds DIV_INIT (default 0) and the load strobe is low.
- R2: A control write with bit 16 set, made while `rx_busy` is low, raises `arm_o` on the next clock. The same write made while `rx_busy` is high is ignored, and `arm_o` stays 0.
- R3: A control write with bit 16 clear, made while armed, drops `arm_o` on the next clock. The measurement is abandoned and no divisor is loaded.
- R4: Measurement begins only at a high-to-low transition of the synchronized line that happens after arming. A line that is already low when the block is armed is not measured. Once a measurement finishes, further pulses load nothing until the block is armed again.
- R5: When the line returns high after a low period of W clocks with 16 <= W <= 2^CNT_W-1, `div_o` becomes floor(W/16)-1. In the same clock `div_load` pulses for one cycle and `arm_o` falls. For example, W=16 gives 0, W=31 gives 0, W=32 gives 1 and W=160 gives 9.
- R6: A low period shorter than 16 clocks sets `err_o` and clears `arm_o`. No load pulse is produced and `div_o` is unchanged.
- R7: A low period longer than 2^CNT_W-1 clocks (4095 by default) sets `err_o` and clears `arm_o` while the line is still low. No load pulse is produced and `div_o` is unchanged.
- R8: `err_o` stays set until `err_clr` is pulsed. A new error in the same cycle as a clear wins over the clear.
- R9: While the block is not armed, activity on `rx_in` never changes `div_o` or pulses `div_load`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_in | input | 1 | Asynchronous serial receive line, idle high |
| rx_busy | input | 1 | High while the receiver is in the middle of a character |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word; bit 16 is the autobaud enable |
| err_clr | input | 1 | One-cycle pulse that clears the error flag |
| arm_o | output | 1 | Autobaud enable readback; clears itself |
| err_o | output | 1 | Sticky autobaud error flag |
| div_o | output | DIV_W (8) | Baud-generator divisor register |
| div_load | output | 1 | One-cycle strobe that marks a new divisor |

## Verification
The assertions assume that the control write strobe, the busy flag and the error clear are synchronous to `clk` and are only meaningful when reset is low. The only input they tolerate as asynchronous is `rx_in`. The bench drives every input on the falling clock edge, so no input changes near the sampling edge. It also holds `rx_in` high for several clocks between pulses, so the synchronizer always sees a clean edge. The bench changes `rx_busy` only while no arm request is being written.

// File: rtl/abd_pkg.sv
package abd_pkg;

    localparam int CTRL_W  = 32;
    localparam int ARM_BIT = 16;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_HUNT = 2'd1,
        ST_TIME = 2'd2
    } abd_state_e;

    typedef struct packed {
        logic fell;
        logic level;
    } line_ev_t;

    function automatic logic arm_field(input logic [CTRL_W-1:0] word);
        return word[ARM_BIT];
    endfunction

endpackage

// File: rtl/abd_line_sync.sv
module abd_line_sync #(
    parameter int STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rx_in,
    output abd_pkg::line_ev_t  ev
);
    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b1;
                else     chain[i] <= (i == 0) ? rx_in : chain[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b1;
        else     prev <= chain[STAGES-1];
    end

    assign ev.level = chain[STAGES-1];
    assign ev.fell  = prev & ~chain[STAGES-1];
endmodule

// File: rtl/abd_width_cnt.sv
module abd_width_cnt #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt,
    output logic             full
);
    always_ff @(posedge clk) begin
        if (rst)        cnt <= '0;
        else if (start) cnt <= CNT_W'(1);
        else if (inc)   cnt <= cnt + CNT_W'(1);
    end

    assign full = &cnt;
endmodule

// File: rtl/abd_seq.sv
module abd_seq
    import abd_pkg::*;
#(
    parameter int CNT_W    = 12,
    parameter int OSR      = 16,
    parameter int DIV_W    = 8,
    parameter int DIV_INIT = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_we,
    input  logic             arm_req,
    input  logic             rx_busy,
    input  logic             err_clr,
    input  line_ev_t         ev,
    input  logic [CNT_W-1:0] cnt,
    input  logic             full,
    output logic             cnt_start,
    output logic             cnt_inc,
    output logic             arm_o,
    output logic             err_o,
    output logic [DIV_W-1:0] div_o,
    output logic             div_load
);
    localparam int OSR_LOG = $clog2(OSR);

    abd_state_e       state;
    logic [DIV_W-1:0] quo;
    logic             disarm;

    assign quo       = DIV_W'(cnt >> OSR_LOG);
    assign disarm    = ctrl_we && !arm_req;
    assign cnt_start = (state == ST_HUNT) && !disarm && ev.fell;
    assign cnt_inc   = (state == ST_TIME) && !ev.level && !full;
    assign arm_o     = (state != ST_OFF);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_OFF;
            err_o    <= 1'b0;
            div_o    <= DIV_W'(DIV_INIT);
            div_load <= 1'b0;
        end else begin
            div_load <= 1'b0;
            if (err_clr) err_o <= 1'b0;
            case (state)
                ST_OFF: begin
                    if (ctrl_we && arm_req && !rx_busy) state <= ST_HUNT;
                end
                ST_HUNT: begin
                    if (disarm)       state <= ST_OFF;
                    else if (ev.fell) state <= ST_TIME;
                end
                ST_TIME: begin
                    if (disarm) begin
                        state <= ST_OFF;
                    end else if (ev.level) begin
                        state <= ST_OFF;
                        if (cnt < CNT_W'(OSR)) begin
                            err_o <= 1'b1;
                        end else begin
                            div_o    <= quo - DIV_W'(1);
                            div_load <= 1'b1;
                        end
                    end else if (full) begin
                        state <= ST_OFF;
                        err_o <= 1'b1;
                    end
                end
                default: state <= ST_OFF;
            endcase
        end
    end
endmodule

// File: rtl/abd_measure.sv
module abd_measure
    import abd_pkg::*;
#(
    parameter int CNT_W    = 12,
    parameter int OSR      = 16,
    parameter int SYNC_N   = 2,
    parameter int DIV_INIT = 0,
    parameter int DIV_W    = CNT_W - $clog2(OSR)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_in,
    input  logic              rx_busy,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              err_clr,
    output logic              arm_o,
    output logic              err_o,
    output logic [DIV_W-1:0]  div_o,
    output logic              div_load
);
    line_ev_t         ev;
    logic [CNT_W-1:0] cnt;
    logic             full;
    logic             cnt_start;
    logic             cnt_inc;

    abd_line_sync #(.STAGES(SYNC_N)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .rx_in (rx_in),
        .ev    (ev)
    );

    abd_width_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .start (cnt_start),
        .inc   (cnt_inc),
        .cnt   (cnt),
        .full  (full)
    );

    abd_seq #(
        .CNT_W    (CNT_W),
        .OSR      (OSR),
        .DIV_W    (DIV_W),
        .DIV_INIT (DIV_INIT)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .ctrl_we   (ctrl_we),
        .arm_req   (arm_field(ctrl_wdata)),
        .rx_busy   (rx_busy),
        .err_clr   (err_clr),
        .ev        (ev),
        .cnt       (cnt),
        .full      (full),
        .cnt_start (cnt_start),
        .cnt_inc   (cnt_inc),
        .arm_o     (arm_o),
        .err_o     (err_o),
        .div_o     (div_o),
        .div_load  (div_load)
    );
endmodule

// File: rtl/abd_measure_chk.sv
module abd_measure_chk #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_busy,
    input logic             ctrl_we,
    input logic [31:0]      ctrl_wdata,
    input logic             err_clr,
    input logic             arm_o,
    input logic             err_o,
    input logic [DIV_W-1:0] div_o,
    input logic             div_load
);
    // R2: arm request while receiver busy is ignored
    assert_busy_arm_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        (!arm_o && ctrl_we && ctrl_wdata[16] && rx_busy) |=> !arm_o);

    // R3: clearing bit 16 while armed disarms without loading
    assert_abort_disarms_R3: assert property (@(posedge clk) disable iff (rst)
        (arm_o && ctrl_we && !ctrl_wdata[16]) |=> (!arm_o && !div_load));

    // R5: load strobe lasts one cycle and coincides with the enable clearing
    assert_load_single_R5: assert property (@(posedge clk) disable iff (rst)
        div_load |=> !div_load);
    assert_load_disarms_R5: assert property (@(posedge clk) disable iff (rst)
        div_load |-> (!arm_o && $past(arm_o)));

    // R6/R7: a new error never comes with a divisor load
    assert_err_no_load_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(err_o) |-> (!div_load && $stable(div_o)));

    // R8: error flag is sticky until cleared
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (err_o && !err_clr) |=> err_o);

    // R9: divisor changes only together with a load strobe
    assert_div_only_on_load_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(div_o) |-> div_load);
endmodule

bind abd_measure abd_measure_chk #(.DIV_W(DIV_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rx_busy    (rx_busy),
    .ctrl_we    (ctrl_we),
    .ctrl_wdata (ctrl_wdata),
    .err_clr    (err_clr),
    .arm_o      (arm_o),
    .err_o      (err_o),
    .div_o      (div_o),
    .div_load   (div_load)
);

// File: tb/sim_abd_measure.sv
`timescale 1ns/1ps
module sim_abd_measure;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_in = 1'b1;
    logic        rx_busy = 1'b0;
    logic        ctrl_we = 1'b0;
    logic [31:0] ctrl_wdata = '0;
    logic        err_clr = 1'b0;
    logic        arm_o, err_o, div_load;
    logic [7:0]  div_o;

    int checks = 0;
    int errors = 0;
    int loads  = 0;
    logic [7:0] last_div = '0;
    bit done = 0;

    always #5 clk = ~clk;

    abd_measure u0 (
        .clk(clk), .rst(rst), .rx_in(rx_in), .rx_busy(rx_busy),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .err_clr(err_clr),
        .arm_o(arm_o), .err_o(err_o), .div_o(div_o), .div_load(div_load)
    );

    always @(negedge clk) begin
        if (!rst && div_load) begin
            loads    = loads + 1;
            last_div = div_o;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_ctrl(input logic en);
        @(negedge clk);
        ctrl_we    = 1'b1;
        ctrl_wdata = 32'(en) << 16;
        @(negedge clk);
        ctrl_we    = 1'b0;
        ctrl_wdata = '0;
    endtask

    task automatic low_pulse(input int n);
        @(negedge clk);
        rx_in = 1'b0;
        repeat (n) @(negedge clk);
        rx_in = 1'b1;
        idle(8);
    endtask

    task automatic clear_err();
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "arm after reset", int'(arm_o), 0);
        check("R1", "err after reset", int'(err_o), 0);
        check("R1", "div after reset", int'(div_o), 0);
        check("R1", "load after reset", int'(div_load), 0);
    endtask

    task automatic t_busy_and_unarmed();
        int l0 = loads;
        rx_busy = 1'b1;
        write_ctrl(1'b1);
        check("R2", "arm while busy", int'(arm_o), 0);
        rx_busy = 1'b0;
        low_pulse(64);
        check("R9", "loads while unarmed", loads - l0, 0);
        check("R9", "div while unarmed", int'(div_o), 0);
    endtask

    task automatic measure(input int w, input int exp_div);
        int l0 = loads;
        write_ctrl(1'b1);
        check("R2", "arm when idle", int'(arm_o), 1);
        low_pulse(w);
        check("R5", $sformatf("load count w=%0d", w), loads - l0, 1);
        check("R5", $sformatf("div w=%0d", w), int'(last_div), exp_div);
        check("R5", $sformatf("div port w=%0d", w), int'(div_o), exp_div);
        check("R5", "arm cleared after load", int'(arm_o), 0);
    endtask

    task automatic t_once();
        int l0 = loads;
        int d0 = int'(div_o);
        low_pulse(96);
        check("R4", "no load without rearm", loads - l0, 0);
        check("R4", "div kept without rearm", int'(div_o), d0);
    endtask

    task automatic t_short();
        int l0 = loads;
        int d0 = int'(div_o);
        write_ctrl(1'b1);
        low_pulse(15);
        check("R6", "err on short", int'(err_o), 1);
        check("R6", "arm cleared on short", int'(arm_o), 0);
        check("R6", "no load on short", loads - l0, 0);
        check("R6", "div kept on short", int'(div_o), d0);
        idle(20);
        check("R8", "err sticky", int'(err_o), 1);
        clear_err();
        check("R8", "err cleared", int'(err_o), 0);
    endtask

    task automatic t_overflow();
        int l0 = loads;
        int d0 = int'(div_o);
        write_ctrl(1'b1);
        @(negedge clk);
        rx_in = 1'b0;
        repeat (4200) @(negedge clk);
        check("R7", "err while still low", int'(err_o), 1);
        check("R7", "arm cleared on overflow", int'(arm_o), 0);
        rx_in = 1'b1;
        idle(8);
        check("R7", "no load on overflow", loads - l0, 0);
        check("R7", "div kept on overflow", int'(div_o), d0);
        clear_err();
        check("R8", "err cleared after overflow", int'(err_o), 0);
    endtask

    task automatic t_abort();
        int l0 = loads;
        write_ctrl(1'b1);
        check("R3", "armed before abort", int'(arm_o), 1);
        write_ctrl(1'b0);
        check("R3", "disarmed by abort", int'(arm_o), 0);
        low_pulse(80);
        check("R3", "no load after abort", loads - l0, 0);
    endtask

    task automatic t_low_at_arm();
        int l0 = loads;
        @(negedge clk);
        rx_in = 1'b0;
        idle(6);
        write_ctrl(1'b1);
        idle(30);
        rx_in = 1'b1;
        idle(8);
        check("R4", "no load for line low at arm", loads - l0, 0);
        check("R4", "still armed", int'(arm_o), 1);
        low_pulse(48);
        check("R4", "load after fresh edge", loads - l0, 1);
        check("R4", "div after fresh edge", int'(div_o), 2);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(4);
        rst = 1'b0;
        idle(2);
        t_reset();
        t_busy_and_unarmed();
        measure(160, 9);
        t_once();
        measure(16, 0);
        measure(31, 0);
        measure(32, 1);
        measure(4095, 254);
        t_short();
        t_overflow();
        t_abort();
        t_low_at_arm();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule